// File: doc/BRIEF.md
# Compare Timer with Auto-Increment

This block is one timer frame fed by a free-running 64-bit count from a system counter elsewhere on the chip. Software sees it through a 32-bit register port. The port has a combinational read path and a single-cycle write strobe.

The frame shows the incoming count. It holds a 64-bit absolute compare value, which software can also program and read as a signed 32-bit offset from the current count. A level interrupt status bit goes high once the count reaches the compare value.

A second, periodic mode keeps its own 64-bit target. Enabling the mode arms the target at the current count plus a reload step. Each time the count reaches the target, the frame latches an event and moves the target forward by the step. Software clears the event through the mode's control register, and the mode stays armed.

Every comparison is made against the count value, never against elapsed clock cycles. A counter that slows down or stalls therefore delays events in proportion.

Top module: `cmp_timer_frame`

## Requirements
- R1: After reset the control register (0x2C) reads 0 and `irq_o` is low.
- R2: Offsets 0x00 and 0x04 read the low and high words of `count_i`, and writes to them have no effect.
- R3: Control bit 0 is the enable, bit 1 the mask and bit 2 the read-only status. The status is 1 only when the enable is 1 and, with the periodic mode off, `count_i` >= the compare value. The compare value is at 0x20 (low) and 0x24 (high). One count below the compare value, the status is 0.
- R4: Reading 0x28 returns the low 32 bits of the compare value minus `count_i`.
- R5: Writing 0x28 sets the compare value to `count_i` plus the sign-extended written word.
- R6: `irq_o` equals the status bit with the mask bit clear. A masked timer keeps its status bit but drives `irq_o` low.
- R7: The reload step is at 0x48. At 0x4C, bit 0 enables the periodic mode and bit 1 is the event. When a write turns bit 0 from 0 to 1, the target (0x40 low, 0x44 high) loads `count_i` plus the step and the event clears. A write that keeps bit 0 at 1 does not reload the target.
- R8: With the periodic mode on, the status bit shows the event. One cycle after `count_i` >= the target, the event is 1 and the target has grown by the step.
- R9: A write to 0x4C with bit 1 at 0 clears the event. A write with bit 1 at 1 leaves the event unchanged.
- R10: The count, compare value and target are full 64-bit quantities. Carries into the high word read back correctly.
- R11: Offset 0x10 reads the `FREQ_ID` parameter, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 64 | System count value |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench sweeps the count across the compare point and checks the status and the signed offset at each step. An off-by-one comparator would fire one count early or one count late, and a flipped subtraction would return the negated offset.

It holds the count for sixteen cycles per step. A design that compares against cycles would then fire while the count is still short of the target.

In periodic mode the bench confirms three things. Re-writing the enable must not re-arm the target, since a design that reloads on a level instead of an edge would shift it. A write with the event bit held at 1 must not clear the event. The target must advance exactly one step per event.

Counts just below a 32-bit boundary check that carries reach the high words of the count, the compare value and the target.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CNT_LO   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_FREQ     = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CMP_LO   = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CMP_HI   = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_DELTA    = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_CTL      = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_AUTO_LO  = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_AUTO_HI  = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_RELOAD   = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_AUTO_CTL = 8'h4C;

  localparam int unsigned CTL_EN   = 0;
  localparam int unsigned CTL_MASK = 1;
  localparam int unsigned CTL_STAT = 2;
  localparam int unsigned AC_EN    = 0;
  localparam int unsigned AC_EVT   = 1;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_FREQ,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_DELTA,
    SEL_CTL,
    SEL_AUTO_LO,
    SEL_AUTO_HI,
    SEL_RELOAD,
    SEL_AUTO_CTL
  } reg_sel_e;
endpackage

// File: rtl/cmp_timer_dec.sv
module cmp_timer_dec
  import cmp_timer_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    unique case (addr_i)
      OFF_CNT_LO:   sel_o = SEL_CNT_LO;
      OFF_CNT_HI:   sel_o = SEL_CNT_HI;
      OFF_FREQ:     sel_o = SEL_FREQ;
      OFF_CMP_LO:   sel_o = SEL_CMP_LO;
      OFF_CMP_HI:   sel_o = SEL_CMP_HI;
      OFF_DELTA:    sel_o = SEL_DELTA;
      OFF_CTL:      sel_o = SEL_CTL;
      OFF_AUTO_LO:  sel_o = SEL_AUTO_LO;
      OFF_AUTO_HI:  sel_o = SEL_AUTO_HI;
      OFF_RELOAD:   sel_o = SEL_RELOAD;
      OFF_AUTO_CTL: sel_o = SEL_AUTO_CTL;
      default:      sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/cmp_timer_abs.sv
module cmp_timer_abs #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              wr_delta_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cval_o,
  output logic [DATA_W-1:0] delta_o,
  output logic              reached_o
);
  logic [CNT_W-1:0] cval_q;
  logic [CNT_W-1:0] diff;
  logic [CNT_W-1:0] wdata_sext;

  assign wdata_sext = {{DATA_W{wdata_i[DATA_W-1]}}, wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cval_q <= '0;
    end else if (wr_delta_i) begin
      cval_q <= count_i + wdata_sext;
    end else begin
      if (wr_lo_i) cval_q[DATA_W-1:0]     <= wdata_i;
      if (wr_hi_i) cval_q[CNT_W-1:DATA_W] <= wdata_i;
    end
  end

  assign diff      = cval_q - count_i;
  assign delta_o   = diff[DATA_W-1:0];
  assign reached_o = (count_i >= cval_q);
  assign cval_o    = cval_q;
endmodule

// File: rtl/cmp_timer_auto.sv
module cmp_timer_auto
  import cmp_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              wr_ctl_i,
  input  logic              wr_reload_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o,
  output logic              evt_o,
  output logic [CNT_W-1:0]  val_o,
  output logic [DATA_W-1:0] reload_o
);
  logic              en_q;
  logic              evt_q;
  logic [CNT_W-1:0]  val_q;
  logic [DATA_W-1:0] reload_q;
  logic              start;
  logic              hit;

  assign start = wr_ctl_i & wdata_i[AC_EN] & ~en_q;
  assign hit   = en_q & (count_i >= val_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      evt_q    <= 1'b0;
      val_q    <= '0;
      reload_q <= '0;
    end else begin
      if (wr_reload_i) reload_q <= wdata_i;
      if (wr_ctl_i)    en_q     <= wdata_i[AC_EN];
      if (start) begin
        val_q <= count_i + CNT_W'(reload_q);
        evt_q <= 1'b0;
      end else begin
        if (hit) begin
          evt_q <= 1'b1;
          val_q <= val_q + CNT_W'(reload_q);
        end
        // clear request outranks a same-cycle hit
        if (wr_ctl_i && !wdata_i[AC_EVT]) evt_q <= 1'b0;
      end
    end
  end

  assign en_o     = en_q;
  assign evt_o    = evt_q;
  assign val_o    = val_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/cmp_timer_frame.sv
module cmp_timer_frame
  import cmp_timer_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter logic [31:0] FREQ_ID = 32'h0000_0000,
  localparam int unsigned CNT_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic              ctl_en_q;
  logic              ctl_mask_q;
  logic [CNT_W-1:0]  cval;
  logic [DATA_W-1:0] delta;
  logic              reached;
  logic              ai_en;
  logic              ai_evt;
  logic [CNT_W-1:0]  ai_val;
  logic [DATA_W-1:0] ai_reload;
  logic              istatus;

  cmp_timer_dec u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  cmp_timer_abs #(.DATA_W(DATA_W)) u_abs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_i    (count_i),
    .wr_lo_i    (wr_en_i && sel == SEL_CMP_LO),
    .wr_hi_i    (wr_en_i && sel == SEL_CMP_HI),
    .wr_delta_i (wr_en_i && sel == SEL_DELTA),
    .wdata_i    (wdata_i),
    .cval_o     (cval),
    .delta_o    (delta),
    .reached_o  (reached)
  );

  cmp_timer_auto #(.DATA_W(DATA_W)) u_auto (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .count_i     (count_i),
    .wr_ctl_i    (wr_en_i && sel == SEL_AUTO_CTL),
    .wr_reload_i (wr_en_i && sel == SEL_RELOAD),
    .wdata_i     (wdata_i),
    .en_o        (ai_en),
    .evt_o       (ai_evt),
    .val_o       (ai_val),
    .reload_o    (ai_reload)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_en_q   <= 1'b0;
      ctl_mask_q <= 1'b0;
    end else if (wr_en_i && sel == SEL_CTL) begin
      ctl_en_q   <= wdata_i[CTL_EN];
      ctl_mask_q <= wdata_i[CTL_MASK];
    end
  end

  // periodic mode takes over the status source
  assign istatus = ctl_en_q & (ai_en ? ai_evt : reached);
  assign irq_o   = istatus & ~ctl_mask_q;

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CNT_LO:   rdata_o = count_i[DATA_W-1:0];
      SEL_CNT_HI:   rdata_o = count_i[CNT_W-1:DATA_W];
      SEL_FREQ:     rdata_o = DATA_W'(FREQ_ID);
      SEL_CMP_LO:   rdata_o = cval[DATA_W-1:0];
      SEL_CMP_HI:   rdata_o = cval[CNT_W-1:DATA_W];
      SEL_DELTA:    rdata_o = delta;
      SEL_CTL: begin
        rdata_o[CTL_EN]   = ctl_en_q;
        rdata_o[CTL_MASK] = ctl_mask_q;
        rdata_o[CTL_STAT] = istatus;
      end
      SEL_AUTO_LO:  rdata_o = ai_val[DATA_W-1:0];
      SEL_AUTO_HI:  rdata_o = ai_val[CNT_W-1:DATA_W];
      SEL_RELOAD:   rdata_o = ai_reload;
      SEL_AUTO_CTL: begin
        rdata_o[AC_EN]  = ai_en;
        rdata_o[AC_EVT] = ai_evt;
      end
      default:      rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cmp_timer_frame_chk.sv
module cmp_timer_frame_chk
  import cmp_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  count_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              ctl_en,
  input logic              ctl_mask,
  input logic              istatus,
  input logic              ai_en,
  input logic              ai_evt,
  input logic [CNT_W-1:0]  ai_val,
  input logic [DATA_W-1:0] ai_reload,
  input logic [CNT_W-1:0]  cval
);
  logic wr_auto_ctl;
  logic wr_delta;

  assign wr_auto_ctl = wr_en_i && addr_i == OFF_AUTO_CTL;
  assign wr_delta    = wr_en_i && addr_i == OFF_DELTA;

  p_status_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_en && !ai_en && count_i >= cval) |-> istatus);

  p_status_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_en |-> !istatus);

  p_delta_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_delta |=> cval == $past(count_i) + {{DATA_W{$past(wdata_i[DATA_W-1])}}, $past(wdata_i)});

  p_irq_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctl_en && !ctl_mask));

  p_arm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_auto_ctl && wdata_i[AC_EN] && !ai_en) |=>
      (ai_val == $past(count_i) + CNT_W'($past(ai_reload)) && !ai_evt));

  p_advance_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ai_en && count_i >= ai_val && !wr_auto_ctl) |=>
      (ai_evt && ai_val == $past(ai_val) + CNT_W'($past(ai_reload))));

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_auto_ctl && !wdata_i[AC_EVT]) |=> !ai_evt);
endmodule

bind cmp_timer_frame cmp_timer_frame_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .count_i   (count_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .irq_o     (irq_o),
  .ctl_en    (ctl_en_q),
  .ctl_mask  (ctl_mask_q),
  .istatus   (istatus),
  .ai_en     (ai_en),
  .ai_evt    (ai_evt),
  .ai_val    (ai_val),
  .ai_reload (ai_reload),
  .cval      (cval)
);

// File: tb/cmp_timer_frame_tb.sv
`timescale 1ns/1ps
module cmp_timer_frame_tb;
  localparam logic [31:0] FREQ = 32'h01E8_4800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmp_timer_frame #(.DATA_W(32), .FREQ_ID(FREQ)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .count_i (cnt),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic expect_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, {32'h0, d}, {32'h0, exp});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_rd("R1 ctl", 8'h2C, 32'h0);
    check("R1 irq", {63'h0, irq}, 64'h0);

    // R2 / R10 count view
    cnt = 64'h1234_5678_9ABC_DEF0;
    expect_rd("R2 cnt lo", 8'h00, 32'h9ABC_DEF0);
    expect_rd("R2 cnt hi", 8'h04, 32'h1234_5678);
    wr(8'h00, 32'hDEAD_BEEF);
    wr(8'h04, 32'hDEAD_BEEF);
    expect_rd("R2 lo after write", 8'h00, 32'h9ABC_DEF0);
    expect_rd("R2 hi after write", 8'h04, 32'h1234_5678);

    // R11 frequency and unmapped
    expect_rd("R11 freq", 8'h10, FREQ);
    expect_rd("R11 unmapped", 8'h30, 32'h0);
    expect_rd("R11 unmapped hi", 8'hFC, 32'h0);

    // R3 disabled timer shows no status
    cnt = 64'd2000;
    wr(8'h20, 32'd1000);
    wr(8'h24, 32'd0);
    expect_rd("R3 disabled status", 8'h2C, 32'h0);
    check("R3 disabled irq", {63'h0, irq}, 64'h0);

    // R3 status bit is read-only
    wr(8'h2C, 32'h5);
    cnt = 64'd10;
    expect_rd("R3 status read-only", 8'h2C, 32'h1);

    // R3 R4 R6 sweep across the compare point
    for (int c = 990; c <= 1010; c++) begin
      cnt = 64'(c);
      expect_rd("R3 sweep ctl", 8'h2C, (c >= 1000) ? 32'h5 : 32'h1);
      expect_rd("R4 sweep delta", 8'h28, 32'(1000 - c));
      check("R6 sweep irq", {63'h0, irq}, (c >= 1000) ? 64'h1 : 64'h0);
    end

    // R6 mask keeps status, drops irq
    wr(8'h2C, 32'h3);
    expect_rd("R6 masked ctl", 8'h2C, 32'h7);
    check("R6 masked irq", {63'h0, irq}, 64'h0);
    wr(8'h2C, 32'h1);
    check("R6 unmasked irq", {63'h0, irq}, 64'h1);

    // R5 delta writes, negative and positive
    cnt = 64'd5000;
    wr(8'h28, 32'hFFFF_FF9C);
    expect_rd("R5 neg lo", 8'h20, 32'd4900);
    expect_rd("R5 neg hi", 8'h24, 32'd0);
    wr(8'h28, 32'd300);
    expect_rd("R5 pos lo", 8'h20, 32'd5300);
    expect_rd("R4 delta readback", 8'h28, 32'd300);
    expect_rd("R3 before target", 8'h2C, 32'h1);

    // R5 R10 carry into the high word
    cnt = 64'h42_FFFF_FF00;
    wr(8'h28, 32'h200);
    expect_rd("R10 cmp lo", 8'h20, 32'h0000_0100);
    expect_rd("R10 cmp hi", 8'h24, 32'h43);

    // R3 compare follows count, not cycles: one count per 16 cycles
    wr(8'h20, 32'd4000);
    wr(8'h24, 32'd0);
    cnt = 64'd3999;
    for (int k = 0; k < 32; k++) begin
      expect_rd("R3 slow count", 8'h2C, (cnt >= 64'd4000) ? 32'h5 : 32'h1);
      if (k == 15) cnt = 64'd4000;
    end

    // R7 arm periodic mode at 4000 with a step of 200
    wr(8'h48, 32'd200);
    expect_rd("R7 reload readback", 8'h48, 32'd200);
    expect_rd("R3 fired before arm", 8'h2C, 32'h5);
    wr(8'h4C, 32'h1);
    expect_rd("R7 target lo", 8'h40, 32'd4200);
    expect_rd("R7 target hi", 8'h44, 32'd0);
    expect_rd("R7 status cleared", 8'h2C, 32'h1);

    // R8 ramp to the target
    for (int c = 4190; c < 4200; c++) begin
      cnt = 64'(c);
      expect_rd("R8 before target", 8'h2C, 32'h1);
    end
    cnt = 64'd4200;
    expect_rd("R8 fired", 8'h2C, 32'h5);
    expect_rd("R8 advanced", 8'h40, 32'd4400);
    check("R8 irq", {63'h0, irq}, 64'h1);
    expect_rd("R9 event visible", 8'h4C, 32'h3);

    // R9 keep vs clear
    wr(8'h4C, 32'h3);
    expect_rd("R9 kept", 8'h2C, 32'h5);
    expect_rd("R7 no rearm on keep", 8'h40, 32'd4400);
    wr(8'h4C, 32'h1);
    expect_rd("R9 cleared", 8'h2C, 32'h1);
    expect_rd("R7 no rearm on clear", 8'h40, 32'd4400);
    expect_rd("R9 mode stays on", 8'h4C, 32'h1);
    cnt = 64'd4400;
    expect_rd("R8 fires again", 8'h2C, 32'h5);
    expect_rd("R8 second advance", 8'h40, 32'd4600);

    // R10 wide count and target
    wr(8'h4C, 32'h0);
    cnt = 64'h42_0000_1130;
    expect_rd("R10 count lo", 8'h00, 32'h1130);
    expect_rd("R10 count hi", 8'h04, 32'h42);
    wr(8'h4C, 32'h1);
    expect_rd("R10 target lo", 8'h40, 32'h11F8);
    expect_rd("R10 target hi", 8'h44, 32'h42);
    wr(8'h4C, 32'h0);
    cnt = 64'h7_FFFF_FFF0;
    wr(8'h4C, 32'h1);
    expect_rd("R10 target carry lo", 8'h40, 32'h0000_00B8);
    expect_rd("R10 target carry hi", 8'h44, 32'h8);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule